// File: doc/BRIEF.md
# Bidirectional Barrel Shifter and Normalizer

This block is a single-cycle word shifter for a floating-point and fixed-point datapath. One shift network does three jobs, and a 3-bit operation code picks the job. Before a floating-point add, it moves the smaller mantissa right by the exponent difference and returns guard, round and sticky bits for the rounding stage. After the add, it finds the leading one, shifts it up to the top bit, and reports the shift distance so that the exponent can be corrected. For integer work it runs arithmetic and logical shifts in both directions, with carry and overflow flags.

The shift is combinational, and every output is captured in a register on the clock edge where `in_valid` is high. The result therefore appears one cycle later and stays there until the next valid operation. Exponent arithmetic, rounding and register access belong to neighbouring blocks. `DATA_W` must be a power of two and `AMT_W` must be wider than log2(`DATA_W`).

Top module: `bshift_norm_unit`

## Requirements
- R1: `out_valid` rises exactly one clock after a cycle in which `in_valid` is high. In a cycle where `in_valid` is low, `out_valid` is low one clock later and all result outputs keep their values.
- R2: While `rst` is high at a clock edge, every output becomes zero at that edge.
- R3: The operation code is: 0 align, 1 normalize, 2 arithmetic left, 3 arithmetic right, 4 logical left, 5 logical right. Codes 6 and 7 pass `data_in` through unchanged with every flag and `lz_count` at zero.
- R4: Align with `shamt` below `DATA_W` gives `data_in` shifted right by `shamt` with zero fill. `guard_out` is input bit `shamt`-1, `round_out` is input bit `shamt`-2, and `sticky_out` is the OR of all input bits below `shamt`-2. Any bit position below zero reads as 0.
- R5: Align with `shamt` of `DATA_W` or more gives a zero result with guard and round clear and `sticky_out` equal to the OR of all input bits.
- R6: Normalize gives in `lz_count` the number of zeros above the highest set bit, and in `data_out` the input shifted left by that count, so that its top bit is set. `lz_count` is zero for every other operation.
- R7: Normalize of an all-zero word gives `lz_count` = `DATA_W`, a zero result and `norm_zero` high. `norm_zero` is low after every other operation.
- R8: The four fixed-point shifts use only the low log2(`DATA_W`) bits of `shamt` as the count n. The logical shifts and arithmetic left fill the vacated positions with zeros.
- R9: Arithmetic right fills the vacated upper positions with copies of input bit `DATA_W`-1.
- R10: For a fixed-point shift, `carry_out` is the last bit pushed out of the word, and it is 0 when n is 0. `carry_out` is 0 for align and normalize.
- R11: `ovf_out` is high after arithmetic left only when the result's top bit differs from the input's top bit, and it is 0 for all other operations. Guard, round and sticky are 0 for every operation except align.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture an operation this cycle |
| op | input | 3 | Operation code (see R3) |
| data_in | input | DATA_W | Operand word or mantissa |
| shamt | input | AMT_W | Exponent difference (align) or shift count (fixed shifts) |
| out_valid | output | 1 | Result registered from the previous cycle's operation |
| data_out | output | DATA_W | Shifted result |
| lz_count | output | log2(DATA_W)+1 | Leading-zero count from normalize |
| norm_zero | output | 1 | Normalize input was zero |
| carry_out | output | 1 | Last bit shifted out by a fixed-point shift |
| ovf_out | output | 1 | Arithmetic-left sign change |
| guard_out | output | 1 | First bit below the aligned result |
| round_out | output | 1 | Second bit below the aligned result |
| sticky_out | output | 1 | OR of the bits below the round position |

## Verification
The bench uses the default build: a 32-bit word and an 8-bit shift amount. An 8-bit amount can express exponent differences from 32 up to 255, so the flush path is tested both at its exact boundary (32) and far beyond it (200). The wide amount also reaches counts above 31 for the fixed-point shifts, which shows that only the low five bits are used. The 32-bit word places the sign bit, the guard/round/sticky split and the all-zero count of 32 at positions the bench can enumerate directly.

// File: rtl/bsn_pkg.sv
package bsn_pkg;

  typedef enum logic [2:0] {
    OP_ALIGN = 3'd0,
    OP_NORM  = 3'd1,
    OP_ASL   = 3'd2,
    OP_ASR   = 3'd3,
    OP_LSL   = 3'd4,
    OP_LSR   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } bsn_op_e;

endpackage

// File: rtl/bsn_lzc.sv
module bsn_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] cnt,
  output logic          all_zero
);

  // Scan from bit 0 upward; the highest set bit is written last and wins.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) cnt = CW'(W - 1 - i);
    end
  end

  assign all_zero = ~|din;

endmodule

// File: rtl/bsn_rshift.sv
module bsn_rshift #(
  parameter int DW   = 64,
  parameter int SH_W = 5
) (
  input  logic [DW-1:0]   din,
  input  logic            fill,
  input  logic [SH_W-1:0] amt,
  output logic [DW-1:0]   dout
);

  logic [DW-1:0] stg [SH_W+1];

  assign stg[0] = din;

  // Logarithmic network: stage g moves the word by 2**g positions.
  for (genvar g = 0; g < SH_W; g++) begin : g_stage
    localparam int D = 1 << g;
    assign stg[g+1] = amt[g] ? {{D{fill}}, stg[g][DW-1:D]} : stg[g];
  end

  assign dout = stg[SH_W];

endmodule

// File: rtl/bshift_norm_unit.sv
module bshift_norm_unit #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [2:0]                 op,
  input  logic [DATA_W-1:0]          data_in,
  input  logic [AMT_W-1:0]           shamt,
  output logic                       out_valid,
  output logic [DATA_W-1:0]          data_out,
  output logic [$clog2(DATA_W):0]    lz_count,
  output logic                       norm_zero,
  output logic                       carry_out,
  output logic                       ovf_out,
  output logic                       guard_out,
  output logic                       round_out,
  output logic                       sticky_out
);
  import bsn_pkg::*;

  localparam int SH_W  = $clog2(DATA_W);
  localparam int CNT_W = SH_W + 1;
  localparam int XW    = 2 * DATA_W;

  bsn_op_e op_e;
  assign op_e = bsn_op_e'(op);

  // Leading-zero count feeds the shared shifter in normalize mode.
  logic [CNT_W-1:0] lz;
  logic             in_zero;

  bsn_lzc #(.W(DATA_W), .CW(CNT_W)) u_lzc (
    .din      (data_in),
    .cnt      (lz),
    .all_zero (in_zero)
  );

  // Left shifts run through the right shifter on a bit-reversed word.
  logic [DATA_W-1:0] data_rev;
  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_in
    assign data_rev[i] = data_in[DATA_W-1-i];
  end

  logic is_left;
  always_comb begin
    case (op_e)
      OP_NORM, OP_ASL, OP_LSL: is_left = 1'b1;
      default:                 is_left = 1'b0;
    endcase
  end

  logic            align_big;
  logic [SH_W-1:0] sh_amt;
  logic            sh_fill;
  logic [XW-1:0]   sh_in;
  logic [XW-1:0]   sh_out;

  assign align_big = (shamt >= AMT_W'(DATA_W));
  assign sh_amt    = (op_e == OP_NORM) ? lz[SH_W-1:0] : shamt[SH_W-1:0];
  assign sh_fill   = (op_e == OP_ASR) & data_in[DATA_W-1];
  assign sh_in     = {(is_left ? data_rev : data_in), {DATA_W{1'b0}}};

  bsn_rshift #(.DW(XW), .SH_W(SH_W)) u_shift (
    .din  (sh_in),
    .fill (sh_fill),
    .amt  (sh_amt),
    .dout (sh_out)
  );

  // Upper half is the result, lower half holds the bits pushed out.
  logic [DATA_W-1:0] hi;
  logic [DATA_W-1:0] lo;
  logic [DATA_W-1:0] hi_rev;

  assign hi = sh_out[XW-1:DATA_W];
  assign lo = sh_out[DATA_W-1:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev_out
    assign hi_rev[i] = hi[DATA_W-1-i];
  end

  logic [DATA_W-1:0] n_data;
  logic [CNT_W-1:0]  n_lz;
  logic              n_zero, n_carry, n_ovf, n_guard, n_round, n_sticky;

  always_comb begin
    n_data   = data_in;
    n_lz     = '0;
    n_zero   = 1'b0;
    n_carry  = 1'b0;
    n_ovf    = 1'b0;
    n_guard  = 1'b0;
    n_round  = 1'b0;
    n_sticky = 1'b0;
    case (op_e)
      OP_ALIGN: begin
        if (align_big) begin
          n_data   = '0;
          n_sticky = ~in_zero;
        end else begin
          n_data   = hi;
          n_guard  = lo[DATA_W-1];
          n_round  = lo[DATA_W-2];
          n_sticky = |lo[DATA_W-3:0];
        end
      end
      OP_NORM: begin
        n_data = hi_rev;
        n_lz   = lz;
        n_zero = in_zero;
      end
      OP_ASL: begin
        n_data  = hi_rev;
        n_carry = lo[DATA_W-1];
        n_ovf   = hi_rev[DATA_W-1] ^ data_in[DATA_W-1];
      end
      OP_LSL: begin
        n_data  = hi_rev;
        n_carry = lo[DATA_W-1];
      end
      OP_ASR, OP_LSR: begin
        n_data  = hi;
        n_carry = lo[DATA_W-1];
      end
      OP_RSV6, OP_RSV7: n_data = data_in;
      default:          n_data = data_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      data_out   <= '0;
      lz_count   <= '0;
      norm_zero  <= 1'b0;
      carry_out  <= 1'b0;
      ovf_out    <= 1'b0;
      guard_out  <= 1'b0;
      round_out  <= 1'b0;
      sticky_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        data_out   <= n_data;
        lz_count   <= n_lz;
        norm_zero  <= n_zero;
        carry_out  <= n_carry;
        ovf_out    <= n_ovf;
        guard_out  <= n_guard;
        round_out  <= n_round;
        sticky_out <= n_sticky;
      end
    end
  end

endmodule

// File: rtl/bsn_checker.sv
module bsn_checker #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [2:0]              op,
  input logic [DATA_W-1:0]       data_in,
  input logic [AMT_W-1:0]        shamt,
  input logic                    out_valid,
  input logic [DATA_W-1:0]       data_out,
  input logic [$clog2(DATA_W):0] lz_count,
  input logic                    norm_zero,
  input logic                    carry_out,
  input logic                    ovf_out,
  input logic                    guard_out,
  input logic                    round_out,
  input logic                    sticky_out
);

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(data_out) && $stable(lz_count)));

  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> (!out_valid && data_out == '0 && !carry_out && !sticky_out));

  p_rsv_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[2:1] == 2'b11) |=>
      (data_out == $past(data_in) && !carry_out && !ovf_out && !sticky_out));

  p_flush_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0 && shamt >= AMT_W'(DATA_W)) |=>
      (data_out == '0 && !guard_out && !round_out && sticky_out == $past(|data_in)));

  p_norm_msb_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd1 && data_in != '0) |=> (data_out[DATA_W-1] && !norm_zero));

  p_norm_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd1 && data_in == '0) |=>
      (norm_zero && data_out == '0 && lz_count == ($clog2(DATA_W)+1)'(DATA_W)));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != 3'd1) |=> (!norm_zero && lz_count == '0));

  p_asr_sign_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd3) |=> (data_out[DATA_W-1] == $past(data_in[DATA_W-1])));

  p_carry_fp_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[2:1] == 2'b00) |=> !carry_out);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != 3'd2) |=> !ovf_out);

  p_grs_align_only_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op != 3'd0) |=> (!guard_out && !round_out && !sticky_out));

endmodule

bind bshift_norm_unit bsn_checker #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .op         (op),
  .data_in    (data_in),
  .shamt      (shamt),
  .out_valid  (out_valid),
  .data_out   (data_out),
  .lz_count   (lz_count),
  .norm_zero  (norm_zero),
  .carry_out  (carry_out),
  .ovf_out    (ovf_out),
  .guard_out  (guard_out),
  .round_out  (round_out),
  .sticky_out (sticky_out)
);

// File: tb/sim_bshift_norm_unit.sv
module sim_bshift_norm_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] data_in = '0;
  logic [7:0]  shamt = '0;
  logic        out_valid;
  logic [31:0] data_out;
  logic [5:0]  lz_count;
  logic        norm_zero, carry_out, ovf_out, guard_out, round_out, sticky_out;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bshift_norm_unit #(.DATA_W(32), .AMT_W(8)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .data_in(data_in),
    .shamt(shamt), .out_valid(out_valid), .data_out(data_out),
    .lz_count(lz_count), .norm_zero(norm_zero), .carry_out(carry_out),
    .ovf_out(ovf_out), .guard_out(guard_out), .round_out(round_out),
    .sticky_out(sticky_out)
  );

  // Packed observation: {valid, data, lzc, zero, carry, ovf, guard, round, sticky}
  function automatic logic [44:0] observe();
    return {out_valid, data_out, lz_count, norm_zero, carry_out, ovf_out,
            guard_out, round_out, sticky_out};
  endfunction

  // Independent reference written bit by bit from the requirements.
  function automatic logic [43:0] model(input logic [2:0] o, input logic [31:0] x,
                                        input logic [7:0] a);
    logic [31:0] d = x;
    logic [5:0]  lzc = '0;
    logic        z = 0, c = 0, v = 0, g = 0, r = 0, s = 0;
    int n = int'(a[4:0]);
    int ai = int'(a);
    case (o)
      3'd0: begin
        if (ai >= 32) begin
          d = '0;
          for (int i = 0; i < 32; i++) s |= x[i];
        end else begin
          for (int i = 0; i < 32; i++) d[i] = (i + ai < 32) ? x[i+ai] : 1'b0;
          if (ai >= 1) g = x[ai-1];
          if (ai >= 2) r = x[ai-2];
          for (int i = 0; i < ai - 2; i++) s |= x[i];
        end
      end
      3'd1: begin
        int k = 0;
        while (k < 32 && !x[31-k]) k++;
        lzc = 6'(k);
        z = (k == 32);
        for (int i = 0; i < 32; i++) d[i] = (i - k >= 0) ? x[i-k] : 1'b0;
      end
      3'd2, 3'd4: begin
        for (int i = 0; i < 32; i++) d[i] = (i - n >= 0) ? x[i-n] : 1'b0;
        if (n > 0) c = x[32-n];
        if (o == 3'd2) v = d[31] != x[31];
      end
      3'd3, 3'd5: begin
        for (int i = 0; i < 32; i++)
          d[i] = (i + n < 32) ? x[i+n] : ((o == 3'd3) ? x[31] : 1'b0);
        if (n > 0) c = x[n-1];
      end
      default: d = x;
    endcase
    return {d, lzc, z, c, v, g, r, s};
  endfunction

  task automatic check(input string tag, input logic [44:0] act, input logic [44:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [43:0] last_exp;

  task automatic apply(input string tag, input logic [2:0] o, input logic [31:0] x,
                       input logic [7:0] a);
    @(negedge clk);
    op = o; data_in = x; shamt = a; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    last_exp = model(o, x, a);
    check(tag, observe(), {1'b1, last_exp});
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R2 reset state", observe(), 45'd0);
    rst = 1'b0;
    apply("R7 norm zero before reset", 3'd1, 32'h0, 8'd0);
    rst = 1'b1;
    @(negedge clk);
    check("R2 reset after result", observe(), 45'd0);
    rst = 1'b0;
  endtask

  task automatic t_align();
    apply("R4 align by 0",            3'd0, 32'hDEADBEEF, 8'd0);
    apply("R4 align by 1 guard only", 3'd0, 32'h80000001, 8'd1);
    apply("R4 align by 2 guard round",3'd0, 32'h00000003, 8'd2);
    apply("R4 align by 5 sticky",     3'd0, 32'h00000015, 8'd5);
    apply("R4 align by 31",           3'd0, 32'hC0000000, 8'd31);
    apply("R5 flush at 32",           3'd0, 32'h00000100, 8'd32);
    apply("R5 flush at 200",          3'd0, 32'hFFFFFFFF, 8'd200);
    apply("R5 flush zero input",      3'd0, 32'h00000000, 8'd40);
  endtask

  task automatic t_norm();
    apply("R6 norm already set",  3'd1, 32'h80000000, 8'd0);
    apply("R6 norm single lsb",   3'd1, 32'h00000001, 8'd9);
    apply("R6 norm mid",          3'd1, 32'h00012345, 8'd0);
    apply("R7 norm all zero",     3'd1, 32'h00000000, 8'd3);
  endtask

  task automatic t_fixed();
    apply("R11 asl overflow",        3'd2, 32'h40000000, 8'd1);
    apply("R11 asl no overflow",     3'd2, 32'h20000000, 8'd1);
    apply("R10 asl carry out",       3'd2, 32'h90000000, 8'd4);
    apply("R9 asr negative",         3'd3, 32'h80000010, 8'd4);
    apply("R9 asr positive",         3'd3, 32'h7000000F, 8'd3);
    apply("R10 asr count zero",      3'd3, 32'hFFFFFFFF, 8'd0);
    apply("R8 lsl zero fill",        3'd4, 32'hFFFF0000, 8'd8);
    apply("R8 lsr zero fill",        3'd5, 32'h80000001, 8'd31);
    apply("R8 count uses low bits",  3'd5, 32'h00000003, 8'd33);
    apply("R10 lsr carry",           3'd5, 32'h00000008, 8'd4);
  endtask

  task automatic t_reserved();
    apply("R3 code 6 passes", 3'd6, 32'h12345678, 8'd7);
    apply("R3 code 7 passes", 3'd7, 32'hFEDCBA98, 8'd250);
  endtask

  task automatic t_hold();
    apply("R1 result before idle", 3'd4, 32'h0000F00F, 8'd12);
    @(negedge clk);
    op = 3'd5; data_in = 32'hAAAAAAAA; shamt = 8'd3;
    @(negedge clk);
    check("R1 idle holds outputs", observe(), {1'b0, last_exp});
    @(negedge clk);
    check("R1 idle second cycle", observe(), {1'b0, last_exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_align();
    t_norm();
    t_fixed();
    t_reserved();
    t_hold();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule